// File: doc/BRIEF.md
# Bit-Serial Distributed Arithmetic FIR Filter

This block computes a K-tap FIR filter over signed samples with no multiplier. Each accepted sample enters a short history of past inputs. All K samples, newest and past, are then loaded into K shift registers. On every clock the least significant bit of each shift register goes to a K-bit address. That address selects one entry of a table with 2^K entries. The table is built at elaboration from the coefficient parameter. Each entry is the sum of the coefficients whose address bit is set.

An accumulator adds each table word, scaled by a power of two that matches the bit position. For the sign-bit position it subtracts the word, which handles two's-complement samples. After W clocks, where W is the sample width, the finished convolution appears on the result port together with a one-cycle valid pulse. While the serial pass is running the block reports busy and drops any new sample offered to it.

Top module: `dafir_top`

## Requirements
- R1: While reset is high and in the cycle after it is released, `busy` and `out_valid` are 0 and `out_result` is 0.
- R2: A sample is accepted on a rising clock edge where `in_valid` is 1 and `busy` is 0. `busy` then reads 1 for exactly W consecutive cycles, starting in the cycle after that edge.
- R3: `out_valid` is 1 for one cycle only, in the cycle after the W-th rising edge that follows the accepting edge. `busy` is 0 in that same cycle.
- R4: In the cycle where `out_valid` is 1, `out_result` (signed) equals sum over k = 0..K-1 of c[k]·x[n-k]. Here x[n] is the sample just accepted and x[n-k] is the sample accepted k acceptances earlier. Samples from before the first acceptance after reset count as zero.
- R5: Coefficient c[k] is `COEFS[k*CW +: CW]`, read as two's complement, and it is applied to the sample of age k. So an impulse (1 followed by zeros) produces c[0], c[1], ... c[K-1] in turn.
- R6: Samples are two's complement with bit W-1 as the sign. The most negative and the most positive sample values give exact results.
- R7: A sample offered while `busy` is 1 is ignored. It does not enter the history and has no effect on any later result.
- R8: Between valid pulses, `out_result` holds the value of the most recent pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample offered this cycle |
| in_data | input | W | Signed input sample |
| busy | output | 1 | Serial pass in progress, input ignored |
| out_valid | output | 1 | One-cycle pulse: result ready |
| out_result | output | W+CW+clog2(K)+1 | Signed filter output |

## Verification
The expected result is due in the cycle after the W-th rising edge that follows the accepting edge. `busy` must be high in each of the W cycles before that. The bench drives inputs on falling edges and samples on falling edges. For every sample it checks `busy` and the absence of `out_valid` in each of those W cycles, then the pulse and the value in the next cycle, all against a bench-side convolution model. Samples offered during a pass are withheld from that model. Their harmlessness then shows in the results of the following samples, and the held output is rechecked several idle cycles after a pulse.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

   // width of one table word: the sum of K coefficients of CW bits
   function automatic int table_width(input int taps, input int cw);
      return cw + $clog2(taps) + 1;
   endfunction

   // width of the finished result
   function automatic int result_width(input int taps, input int cw, input int w);
      return w + table_width(taps, cw);
   endfunction

endpackage

// File: rtl/dafir_delay.sv
module dafir_delay #(
   parameter int K = 4,
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic         shift,
   input  logic [W-1:0] in_data,
   output logic [K-1:0] addr
);

   logic [W-1:0] hist [K-1];
   logic [W-1:0] sreg [K];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int j = 0; j < K-1; j++) hist[j] <= '0;
      end else if (load) begin
         hist[0] <= in_data;
         for (int j = 1; j < K-1; j++) hist[j] <= hist[j-1];
      end
   end

   for (genvar k = 0; k < K; k++) begin : g_tap
      always_ff @(posedge clk) begin
         if (rst) begin
            sreg[k] <= '0;
         end else if (load) begin
            if (k == 0) sreg[k] <= in_data;
            else        sreg[k] <= hist[k-1];
         end else if (shift) begin
            sreg[k] <= {sreg[k][W-1], sreg[k][W-1:1]};
         end
      end
      assign addr[k] = sreg[k][0];
   end

   // R7: the history moves only on an accepted sample
   AST_HIST_HOLD: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(hist[0])) else $error("history moved without load"); // R7

endmodule

// File: rtl/dafir_table.sv
module dafir_table
   import dafir_pkg::*;
#(
   parameter int K  = 4,
   parameter int CW = 8,
   parameter logic [K*CW-1:0] COEFS = '0,
   localparam int TW = table_width(K, CW)
) (
   input  logic [K-1:0]         addr,
   output logic signed [TW-1:0] word
);

   localparam int ENTRIES = 2 ** K;

   function automatic logic signed [TW-1:0] entry_sum(input int idx);
      logic signed [TW-1:0] s;
      s = '0;
      for (int k = 0; k < K; k++) begin
         if (((idx >> k) & 1) == 1)
            s = s + TW'($signed(COEFS[k*CW +: CW]));
      end
      return s;
   endfunction

   logic signed [TW-1:0] rom [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      assign rom[e] = entry_sum(e);
   end

   assign word = rom[addr];

endmodule

// File: rtl/dafir_acc.sv
module dafir_acc
   import dafir_pkg::*;
#(
   parameter int K  = 4,
   parameter int W  = 8,
   parameter int CW = 8,
   localparam int TW   = table_width(K, CW),
   localparam int OW   = result_width(K, CW, W),
   localparam int CNTW = $clog2(W) + 1
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 start,
   input  logic signed [TW-1:0] word,
   output logic                 busy,
   output logic                 done,
   output logic signed [OW-1:0] result
);

   logic [CNTW-1:0]      bitpos;
   logic signed [OW-1:0] acc;
   logic signed [OW-1:0] term;
   logic signed [OW-1:0] next_acc;
   logic                 last;

   assign last = (bitpos == CNTW'(W-1));
   assign term = $signed({{(OW-TW){word[TW-1]}}, word}) <<< bitpos;
   assign next_acc = last ? (acc - term) : (acc + term);

   always_ff @(posedge clk) begin
      if (rst) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         bitpos <= '0;
         acc    <= '0;
         result <= '0;
      end else begin
         done <= 1'b0;
         if (start) begin
            busy   <= 1'b1;
            bitpos <= '0;
            acc    <= '0;
         end else if (busy) begin
            acc    <= next_acc;
            bitpos <= bitpos + 1'b1;
            if (last) begin
               busy   <= 1'b0;
               done   <= 1'b1;
               result <= next_acc;
            end
         end
      end
   end

   // pass length counted independently of bitpos
   logic [CNTW:0] run_len;
   always_ff @(posedge clk) begin
      if (rst)       run_len <= '0;
      else if (busy) run_len <= run_len + 1'b1;
      else           run_len <= '0;
   end

   AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst)
      busy |-> (run_len < (CNTW+1)'(W))) else $error("busy too long"); // R2
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
      $fell(busy) |-> done) else $error("busy fell without done"); // R3
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
      done |=> !done) else $error("done longer than one cycle"); // R3
   AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (rst)
      busy |-> !start) else $error("start while busy"); // R7
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
      !done |-> $stable(result)) else $error("result moved"); // R8

endmodule

// File: rtl/dafir_top.sv
module dafir_top
   import dafir_pkg::*;
#(
   parameter int K  = 4,
   parameter int W  = 8,
   parameter int CW = 8,
   parameter logic [K*CW-1:0] COEFS = {8'sd7, -8'sd3, 8'sd12, 8'sd5},
   localparam int TW = table_width(K, CW),
   localparam int OW = result_width(K, CW, W)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 in_valid,
   input  logic [W-1:0]         in_data,
   output logic                 busy,
   output logic                 out_valid,
   output logic signed [OW-1:0] out_result
);

   if (K < 2 || K > 10) begin : g_bad_k
      $error("K must lie in 2..10");
   end
   if (W < 2 || W > 32) begin : g_bad_w
      $error("W must lie in 2..32");
   end
   if (CW < 2 || CW > 32) begin : g_bad_cw
      $error("CW must lie in 2..32");
   end

   logic                 accept;
   logic [K-1:0]         addr;
   logic signed [TW-1:0] word;

   assign accept = in_valid & ~busy;

   dafir_delay #(.K(K), .W(W)) u_delay (
      .clk(clk), .rst(rst), .load(accept), .shift(busy),
      .in_data(in_data), .addr(addr)
   );

   dafir_table #(.K(K), .CW(CW), .COEFS(COEFS)) u_table (
      .addr(addr), .word(word)
   );

   dafir_acc #(.K(K), .W(W), .CW(CW)) u_acc (
      .clk(clk), .rst(rst), .start(accept), .word(word),
      .busy(busy), .done(out_valid), .result(out_result)
   );

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
      accept |=> busy) else $error("accepted sample did not start a pass"); // R2

endmodule

// File: tb/tb_dafir_top.sv
module tb_dafir_top;
   localparam int K  = 4;
   localparam int W  = 8;
   localparam int CW = 8;
   localparam int OW = W + CW + $clog2(K) + 1;

   // bench copy of the coefficient values, tap 0 first (R5)
   int coef [K] = '{5, 12, -3, 7};

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic in_valid = 1'b0;
   logic [W-1:0] in_data = '0;
   logic busy, out_valid;
   logic signed [OW-1:0] out_result;

   int tests = 0;
   int fails = 0;
   bit finished = 0;
   int hist [K];
   int last_expect = 0;

   always #4 clk = ~clk;

   dafir_top dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .busy(busy), .out_valid(out_valid), .out_result(out_result)
   );

   task automatic check(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // run one sample; noise>0 offers extra samples during the pass (R7)
   task automatic run_sample(input int x, input int noise, input string tag);
      int y;
      for (int k = K-1; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
      y = 0;
      for (int k = 0; k < K; k++) y += coef[k] * hist[k];
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = W'(x);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      for (int c = 0; c < W; c++) begin
         if (c > 0) @(negedge clk);
         check({tag, " R2 busy"}, int'(busy), 1);
         check({tag, " R3 early"}, int'(out_valid), 0);
         if (noise > 0 && c < W-1) begin
            in_valid = 1'b1;
            in_data  = W'(noise + c);
         end else begin
            in_valid = 1'b0;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      check({tag, " R3 valid"}, int'(out_valid), 1);
      check({tag, " R3 busy low"}, int'(busy), 0);
      check({tag, " R4 result"}, int'(out_result), y);
      last_expect = y;
   endtask

   task automatic t_reset();
      rst = 1'b1;
      for (int k = 0; k < K; k++) hist[k] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 busy", int'(busy), 0);
      check("R1 valid", int'(out_valid), 0);
      check("R1 result", int'(out_result), 0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 busy after release", int'(busy), 0);
      check("R1 result after release", int'(out_result), 0);
   endtask

   task automatic t_impulse();
      run_sample(1, 0, "R5 impulse");
      for (int k = 1; k < K + 1; k++) run_sample(0, 0, "R5 impulse tail");
   endtask

   task automatic t_extremes();
      for (int i = 0; i < K + 1; i++) run_sample(-(1 << (W-1)), 0, "R6 min");
      for (int i = 0; i < K + 1; i++) run_sample((1 << (W-1)) - 1, 0, "R6 max");
      run_sample(-(1 << (W-1)), 0, "R6 swing");
      run_sample(-1, 0, "R6 minus one");
   endtask

   task automatic t_pattern();
      int s = 13;
      for (int i = 0; i < 20; i++) begin
         s = (s * 37 + 11) % 256;
         run_sample(s - 128, 0, "R4 pattern");
      end
   endtask

   task automatic t_ignore();
      run_sample(9, 100, "R7 noisy");
      run_sample(-20, 57, "R7 noisy");
      run_sample(3, 0, "R7 after noise");
      run_sample(0, 0, "R7 after noise");
   endtask

   task automatic t_hold();
      repeat (5) @(negedge clk);
      check("R8 hold value", int'(out_result), last_expect);
      check("R8 no pulse", int'(out_valid), 0);
   endtask

   initial begin
      t_reset();
      t_impulse();
      t_pattern();
      t_extremes();
      t_ignore();
      t_hold();
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #400000;
      if (!finished) begin
         tests++;
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule